// File: doc/BRIEF.md
# Processor Interrupt Entry Unit

This unit is the system-control logic that sits beside a processor pipeline. It turns asynchronous device interrupt requests into a precise transfer of control that happens only between instructions. It holds three system registers, which software reaches through a register-numbered move port:

- a status word, holding a global enable, an exception-level flag, a kernel flag and one mask bit per request line;
- a cause word, which shows the synchronised request lines;
- an exception PC.

When the pipeline reports an instruction boundary, the unit decides whether to take an interrupt. It does so when:

- the global enable is set,
- the exception-level flag is clear, and
- at least one pending line is unmasked.

Taking an interrupt has three effects in a single step. It stores the boundary PC in the exception PC, sets the exception-level flag (which also puts the processor in kernel mode), and drives a one-cycle redirect to the single fixed vector 0x80000180. Every source shares that vector. The handler reads the cause word to find which line needs service. A return request reverses the entry: it clears the exception-level flag and redirects to the saved exception PC.

Control is a three-state machine:

- `ST_RUN` is normal execution.
- `ST_ENTER` presents the vector redirect.
- `ST_LEAVE` presents the return redirect.

The machine has four transitions:

- `T_TAKE` goes from `ST_RUN` to `ST_ENTER` when an interrupt is accepted at a boundary.
- `T_ERET` goes from `ST_RUN` to `ST_LEAVE` when a return is requested while the exception-level flag is set.
- `T_ENTER_DONE` goes from `ST_ENTER` back to `ST_RUN`.
- `T_LEAVE_DONE` goes from `ST_LEAVE` back to `ST_RUN`.

Each redirect state lasts exactly one cycle.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset the status word reads 0x00000004 (only the kernel flag, bit 2, set), cause and exception PC read 0, redirect_valid is 0 and kernel_mode is 1.
- R2: Cause bits 15:8 show request lines 7:0 two clock edges after they change, and not after one. Writes to the cause register number (13) are ignored.
- R3: With status bit 0 (global enable) set, bit 1 (exception level) clear and a pending line whose mask bit in status 15:8 is set, a cycle with instr_boundary high leads, in the next cycle, to the following:
  - redirect_valid is high with redirect_pc 0x80000180;
  - the exception PC holds boundary_pc;
  - status bit 1 reads 1;
  - kernel_mode is 1.
- R4: No interrupt is taken while the global enable is clear, or while every pending line is masked.
- R5: While the exception-level flag is set, whether by an earlier interrupt or by a software write, no interrupt is taken.
- R6: No interrupt is taken in a cycle where instr_boundary is low, however long a request has been pending.
- R7: eret_req while the exception-level flag is set gives, in the next cycle, a redirect to the current exception PC (including a value software wrote there). The flag is clear in that cycle, and kernel_mode falls back to status bit 2.
- R8: eret_req while the exception-level flag is clear is ignored: there is no redirect and status does not change.
- R9: The move port, with status at register 12, cause at 13 and exception PC at 14, behaves as follows:
  - status bits 0, 1, 2 and 15:8 are writable, and its other bits read 0;
  - all 32 bits of the exception PC are writable;
  - any other register number reads 0.
- R10: A redirect lasts exactly one cycle. An instr_boundary held high across the entry produces a single redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 8 | Asynchronous device request lines |
| instr_boundary | input | 1 | Pipeline is between two instructions this cycle |
| boundary_pc | input | 32 | Address of the instruction about to execute |
| eret_req | input | 1 | Return-from-interrupt request |
| mv_we | input | 1 | Move-to write strobe |
| mv_addr | input | 5 | System register number |
| mv_wdata | input | 32 | Move-to write data |
| mv_rdata | output | 32 | Move-from read data (combinational) |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | 32 | Redirect target |
| kernel_mode | output | 1 | Processor runs privileged |

## Verification
The take decision is driven with request patterns that isolate each gate in turn:

- a pending line whose mask bit is clear, while a different line's mask bit is set, which separates per-line masking from a plain OR of the requests;
- a pending, unmasked line with the global enable clear;
- a pending line with no boundary;
- a boundary that falls while the exception-level flag is set, once from hardware entry and once from a software write.

A boundary held high through an entry tells a single-cycle redirect apart from a repeated one. Returns are tried both with the saved PC and with a PC that software has overwritten, and also with the flag clear. This shows that the return target comes from the live register and that a stray return has no effect.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    // control flow of the entry unit
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_LEAVE = 2'd2
    } flow_state_e;

    // status word field positions
    localparam int unsigned IE_BIT   = 0;
    localparam int unsigned EXL_BIT  = 1;
    localparam int unsigned KRN_BIT  = 2;
    localparam int unsigned MASK_LSB = 8;

    // width of the move-port register number
    localparam int unsigned REGNUM_W = 5;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int unsigned LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);

    logic [LINES-1:0] meta_q;
    logic [LINES-1:0] sync_q;

    // two-flop synchroniser per request line
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b0;
                sync_q[g] <= 1'b0;
            end else begin
                meta_q[g] <= async_i[g];
                sync_q[g] <= meta_q[g];
            end
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/irq_sysregs.sv
module irq_sysregs
    import irq_entry_pkg::*;
#(
    parameter int unsigned          XLEN       = 32,
    parameter int unsigned          LINES      = 8,
    parameter logic [REGNUM_W-1:0]  REG_STATUS = 5'd12,
    parameter logic [REGNUM_W-1:0]  REG_CAUSE  = 5'd13,
    parameter logic [REGNUM_W-1:0]  REG_EPC    = 5'd14
) (
    input  logic                clk,
    input  logic                rst_n,
    // hardware events from the control FSM
    input  logic                take_i,
    input  logic                eret_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [LINES-1:0]    ip_i,
    // software move port
    input  logic                mv_we_i,
    input  logic [REGNUM_W-1:0] mv_addr_i,
    input  logic [XLEN-1:0]     mv_wdata_i,
    output logic [XLEN-1:0]     mv_rdata_o,
    // register contents
    output logic                ie_o,
    output logic                exl_o,
    output logic                krn_o,
    output logic [LINES-1:0]    mask_o,
    output logic [XLEN-1:0]     epc_o
);

    logic             ie_q;
    logic             exl_q;
    logic             krn_q;
    logic [LINES-1:0] mask_q;
    logic [XLEN-1:0]  epc_q;

    // hardware entry/return wins over a software write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            exl_q  <= 1'b0;
            krn_q  <= 1'b1;
            mask_q <= '0;
            epc_q  <= '0;
        end else if (take_i) begin
            exl_q <= 1'b1;
            epc_q <= pc_i;
        end else if (eret_i) begin
            exl_q <= 1'b0;
        end else if (mv_we_i) begin
            if (mv_addr_i == REG_STATUS) begin
                ie_q   <= mv_wdata_i[IE_BIT];
                exl_q  <= mv_wdata_i[EXL_BIT];
                krn_q  <= mv_wdata_i[KRN_BIT];
                mask_q <= mv_wdata_i[MASK_LSB +: LINES];
            end else if (mv_addr_i == REG_EPC) begin
                epc_q <= mv_wdata_i;
            end
        end
    end

    // move-from read mux; unmapped numbers and unused bits read zero
    always_comb begin
        mv_rdata_o = '0;
        if (mv_addr_i == REG_STATUS) begin
            mv_rdata_o[IE_BIT]            = ie_q;
            mv_rdata_o[EXL_BIT]           = exl_q;
            mv_rdata_o[KRN_BIT]           = krn_q;
            mv_rdata_o[MASK_LSB +: LINES] = mask_q;
        end else if (mv_addr_i == REG_CAUSE) begin
            mv_rdata_o[MASK_LSB +: LINES] = ip_i;
        end else if (mv_addr_i == REG_EPC) begin
            mv_rdata_o = epc_q;
        end
    end

    assign ie_o   = ie_q;
    assign exl_o  = exl_q;
    assign krn_o  = krn_q;
    assign mask_o = mask_q;
    assign epc_o  = epc_q;

    // R3: an accepted interrupt captures the boundary PC and raises the level flag
    p_take_saves_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (epc_q == $past(pc_i)) && exl_q);

    // R7: a return leaves the level flag clear
    p_eret_clears_exl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eret_i |=> !exl_q);

    // R8: the FSM only issues a return while the level flag is held
    p_eret_needs_exl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eret_i |-> exl_q);

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int unsigned     XLEN   = 32,
    parameter int unsigned     LINES  = 8,
    parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             eret_req_i,
    input  logic             ie_i,
    input  logic             exl_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [LINES-1:0] ip_i,
    input  logic [XLEN-1:0]  epc_i,
    output logic             take_o,
    output logic             eret_o,
    output logic             redirect_valid_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output flow_state_e      state_o
);

    flow_state_e state_q;
    flow_state_e state_d;
    logic        any_unmasked;

    assign any_unmasked = |(ip_i & mask_i);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions and decision strobes
    always_comb begin
        state_d = state_q;
        take_o  = 1'b0;
        eret_o  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (boundary_i && ie_i && !exl_i && any_unmasked) begin
                    take_o  = 1'b1;          // T_TAKE
                    state_d = ST_ENTER;
                end else if (eret_req_i && exl_i) begin
                    eret_o  = 1'b1;          // T_ERET
                    state_d = ST_LEAVE;
                end
            end
            ST_ENTER: state_d = ST_RUN;      // T_ENTER_DONE
            ST_LEAVE: state_d = ST_RUN;      // T_LEAVE_DONE
            default:  state_d = ST_RUN;
        endcase
    end

    // redirect outputs
    always_comb begin
        redirect_valid_o = 1'b0;
        redirect_pc_o    = '0;
        unique case (state_q)
            ST_RUN: begin
                redirect_valid_o = 1'b0;
            end
            ST_ENTER: begin
                redirect_valid_o = 1'b1;
                redirect_pc_o    = VECTOR;
            end
            ST_LEAVE: begin
                redirect_valid_o = 1'b1;
                redirect_pc_o    = epc_i;
            end
            default: begin
                redirect_valid_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

    // R10: each redirect is a single-cycle pulse
    p_redirect_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |=> !redirect_valid_o);

    // R3: the cycle after a take presents the entry with the flag already raised
    p_enter_after_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (state_q == ST_ENTER) && exl_i);

    // R7: the return redirect is presented with the flag already cleared
    p_leave_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAVE) |-> !exl_i);

    // R5: the cycle after an entry never accepts another interrupt
    p_no_nested_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter int unsigned          XLEN       = 32,
    parameter int unsigned          LINES      = 8,
    parameter logic [XLEN-1:0]      VECTOR     = 32'h8000_0180,
    parameter logic [REGNUM_W-1:0]  REG_STATUS = 5'd12,
    parameter logic [REGNUM_W-1:0]  REG_CAUSE  = 5'd13,
    parameter logic [REGNUM_W-1:0]  REG_EPC    = 5'd14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LINES-1:0]    dev_irq,
    input  logic                instr_boundary,
    input  logic [XLEN-1:0]     boundary_pc,
    input  logic                eret_req,
    input  logic                mv_we,
    input  logic [REGNUM_W-1:0] mv_addr,
    input  logic [XLEN-1:0]     mv_wdata,
    output logic [XLEN-1:0]     mv_rdata,
    output logic                redirect_valid,
    output logic [XLEN-1:0]     redirect_pc,
    output logic                kernel_mode
);

    logic [LINES-1:0] ip;
    logic             take;
    logic             eret;
    logic             ie;
    logic             exl;
    logic             krn;
    logic [LINES-1:0] mask;
    logic [XLEN-1:0]  epc;
    flow_state_e      fsm_state;

    irq_line_sync #(
        .LINES (LINES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (dev_irq),
        .sync_o  (ip)
    );

    irq_sysregs #(
        .XLEN       (XLEN),
        .LINES      (LINES),
        .REG_STATUS (REG_STATUS),
        .REG_CAUSE  (REG_CAUSE),
        .REG_EPC    (REG_EPC)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .eret_i     (eret),
        .pc_i       (boundary_pc),
        .ip_i       (ip),
        .mv_we_i    (mv_we),
        .mv_addr_i  (mv_addr),
        .mv_wdata_i (mv_wdata),
        .mv_rdata_o (mv_rdata),
        .ie_o       (ie),
        .exl_o      (exl),
        .krn_o      (krn),
        .mask_o     (mask),
        .epc_o      (epc)
    );

    irq_entry_fsm #(
        .XLEN   (XLEN),
        .LINES  (LINES),
        .VECTOR (VECTOR)
    ) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .boundary_i       (instr_boundary),
        .eret_req_i       (eret_req),
        .ie_i             (ie),
        .exl_i            (exl),
        .mask_i           (mask),
        .ip_i             (ip),
        .epc_i            (epc),
        .take_o           (take),
        .eret_o           (eret),
        .redirect_valid_o (redirect_valid),
        .redirect_pc_o    (redirect_pc),
        .state_o          (fsm_state)
    );

    // privileged whenever the level flag or the kernel flag is set
    assign kernel_mode = exl | krn;

    // R3: the vector redirect is always issued in kernel mode
    p_kernel_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_ENTER) |-> kernel_mode);

endmodule

// File: tb/test_irq_entry_unit.sv
module test_irq_entry_unit;

    localparam logic [31:0] VEC  = 32'h8000_0180;
    localparam logic [4:0]  RSTA = 5'd12;
    localparam logic [4:0]  RCAU = 5'd13;
    localparam logic [4:0]  REPC = 5'd14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dev_irq = '0;
    logic        instr_boundary = 1'b0;
    logic [31:0] boundary_pc = '0;
    logic        eret_req = 1'b0;
    logic        mv_we = 1'b0;
    logic [4:0]  mv_addr = '0;
    logic [31:0] mv_wdata = '0;
    logic [31:0] mv_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        kernel_mode;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    logic [31:0] rd;

    always #5 clk = ~clk;

    irq_entry_unit i_irq_entry_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .dev_irq        (dev_irq),
        .instr_boundary (instr_boundary),
        .boundary_pc    (boundary_pc),
        .eret_req       (eret_req),
        .mv_we          (mv_we),
        .mv_addr        (mv_addr),
        .mv_wdata       (mv_wdata),
        .mv_rdata       (mv_rdata),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .kernel_mode    (kernel_mode)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected redirect target per redirect seen
    always @(negedge clk) begin
        if (rst_n && redirect_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected redirect", redirect_pc, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(redirect_pc == e, "R3/R7 redirect target", redirect_pc, e);
            end
        end
    end

    task automatic mv_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        mv_we = 1'b1; mv_addr = a; mv_wdata = d;
        @(negedge clk);
        mv_we = 1'b0;
    endtask

    task automatic mv_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        mv_addr = a;
        #1 d = mv_rdata;
    endtask

    task automatic pulse_boundary(input logic [31:0] pc, input bit expect_take);
        @(negedge clk);
        instr_boundary = 1'b1; boundary_pc = pc;
        if (expect_take) exp_q.push_back(VEC);
        @(negedge clk);
        instr_boundary = 1'b0;
    endtask

    task automatic pulse_eret(input bit expect_ret, input logic [31:0] target);
        @(negedge clk);
        eret_req = 1'b1;
        if (expect_ret) exp_q.push_back(target);
        @(negedge clk);
        eret_req = 1'b0;
    endtask

    task automatic drained(input string req);
        @(negedge clk);
        #1 check(exp_q.size() == 0, req, exp_q.size(), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        mv_read(RSTA, rd); check(rd == 32'h4, "R1 status", rd, 32'h4);
        mv_read(RCAU, rd); check(rd == 32'h0, "R1 cause", rd, 32'h0);
        mv_read(REPC, rd); check(rd == 32'h0, "R1 epc", rd, 32'h0);
        check({31'b0, redirect_valid} == 32'h0, "R1 redirect_valid", {31'b0, redirect_valid}, 32'h0);
        check(kernel_mode == 1'b1, "R1 kernel_mode", {31'b0, kernel_mode}, 32'h1);

        // R9 move port
        mv_write(RSTA, 32'hFFFF_FFFF);
        mv_read(RSTA, rd); check(rd == 32'h0000_FF07, "R9 status writable bits", rd, 32'h0000_FF07);
        mv_write(RSTA, 32'h0);
        mv_read(RSTA, rd); check(rd == 32'h0, "R9 status cleared", rd, 32'h0);
        check(kernel_mode == 1'b0, "R9 kernel_mode follows flags", {31'b0, kernel_mode}, 32'h0);
        mv_write(REPC, 32'hDEAD_BEEC);
        mv_read(REPC, rd); check(rd == 32'hDEAD_BEEC, "R9 epc write", rd, 32'hDEAD_BEEC);
        mv_read(5'd3, rd); check(rd == 32'h0, "R9 unmapped reads zero", rd, 32'h0);
        mv_write(RCAU, 32'hFFFF_FFFF);
        mv_read(RCAU, rd); check(rd == 32'h0, "R2 cause write ignored", rd, 32'h0);

        // R2 two-edge synchroniser latency
        @(negedge clk); dev_irq = 8'h05;
        mv_read(RCAU, rd); check(rd == 32'h0, "R2 not after one edge", rd, 32'h0);
        mv_read(RCAU, rd); check(rd == 32'h0000_0500, "R2 after two edges", rd, 32'h0000_0500);

        // R4 global enable clear, line0 unmasked
        mv_write(RSTA, 32'h0000_0100);
        pulse_boundary(32'h0000_0800, 1'b0);
        drained("R4 no take with enable clear");
        mv_read(RSTA, rd); check(rd == 32'h0000_0100, "R4 status untouched", rd, 32'h0000_0100);

        // R4 enable set, only non-pending line1 unmasked
        mv_write(RSTA, 32'h0000_0201);
        pulse_boundary(32'h0000_0900, 1'b0);
        drained("R4 no take when pending lines masked");
        mv_read(RSTA, rd); check(rd == 32'h0000_0201, "R4 exl stays clear", rd, 32'h0000_0201);

        // R6 pending and enabled but no boundary
        mv_write(RSTA, 32'h0000_0401);
        repeat (4) @(negedge clk);
        drained("R6 no take without boundary");
        mv_read(RSTA, rd); check(rd == 32'h0000_0401, "R6 exl stays clear", rd, 32'h0000_0401);

        // R3 take on line2
        pulse_boundary(32'h0000_1000, 1'b1);
        drained("R3 vector redirect issued");
        mv_read(REPC, rd); check(rd == 32'h0000_1000, "R3 epc captured", rd, 32'h0000_1000);
        mv_read(RSTA, rd); check(rd == 32'h0000_0403, "R3 exl set", rd, 32'h0000_0403);
        check(kernel_mode == 1'b1, "R3 kernel_mode", {31'b0, kernel_mode}, 32'h1);

        // R5 level flag blocks nested take
        pulse_boundary(32'h0000_2000, 1'b0);
        drained("R5 no nested take");
        mv_read(REPC, rd); check(rd == 32'h0000_1000, "R5 epc kept", rd, 32'h0000_1000);

        // R7 return
        pulse_eret(1'b1, 32'h0000_1000);
        drained("R7 return redirect issued");
        mv_read(RSTA, rd); check(rd == 32'h0000_0401, "R7 exl cleared", rd, 32'h0000_0401);
        check(kernel_mode == 1'b0, "R7 kernel_mode restored", {31'b0, kernel_mode}, 32'h0);

        // R8 stray return ignored
        pulse_eret(1'b0, 32'h0);
        drained("R8 no redirect");
        mv_read(RSTA, rd); check(rd == 32'h0000_0401, "R8 status unchanged", rd, 32'h0000_0401);

        // R10 boundary held high across entry
        @(negedge clk);
        instr_boundary = 1'b1; boundary_pc = 32'h0000_3000;
        exp_q.push_back(VEC);
        repeat (4) @(negedge clk);
        instr_boundary = 1'b0;
        drained("R10 single redirect");
        mv_read(REPC, rd); check(rd == 32'h0000_3000, "R10 epc from first boundary", rd, 32'h0000_3000);

        // R7 return to software-modified epc
        mv_write(REPC, 32'h0000_4444);
        pulse_eret(1'b1, 32'h0000_4444);
        drained("R7 return to written epc");

        // R5 flag set by software write
        mv_write(RSTA, 32'h0000_0403);
        pulse_boundary(32'h0000_5000, 1'b0);
        drained("R5 software exl blocks");
        mv_read(REPC, rd); check(rd == 32'h0000_4444, "R5 epc untouched", rd, 32'h0000_4444);
        mv_write(RSTA, 32'h0000_0401);

        // R2 lines drop
        @(negedge clk); dev_irq = 8'h00;
        mv_read(RCAU, rd); check(rd == 32'h0000_0500, "R2 drop not after one edge", rd, 32'h0000_0500);
        mv_read(RCAU, rd); check(rd == 32'h0, "R2 drop after two edges", rd, 32'h0);
        pulse_boundary(32'h0000_6000, 1'b0);
        drained("R4 nothing pending no take");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule